// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block is the host-side driver for an eight-channel serial digital-to-analog converter that listens on a three-wire bus made of a shift clock, a data line and a latch strobe, plus a separate global update strobe. A client hands the sequencer one write at a time through a valid/ready request port. Each write carries a channel number, a range-doubling bit, an 8-bit code and a defer flag. The sequencer turns the write into a 12-bit serial frame, pulses the latch strobe, and raises a one-cycle `done` when the frame is finished.

The two update modes differ only in the update strobe. In immediate mode the update strobe is held low for the whole write, so the converter output follows as soon as the latch strobe falls. In deferred mode the update strobe stays high, and the converter keeps the new value pending. A later commit request then pulses the update strobe low once, which moves all pending channels to their outputs together.

Every interval on the bus is a whole number of system clock cycles. Each count is derived from a nanosecond parameter and the system clock period, rounded up. The derived counts respect these limits:
- the maximum shift clock rate;
- data setup and hold around each falling shift edge;
- the gap between the latch strobe and the shift clock;
- the minimum widths of both strobes.

Top module: `dacbus_sequencer`

## Requirements
- R1: Out of reset, the outputs are at their idle levels: `bus_sclk` low, `bus_load_n` high, `bus_ldac_n` high, `bus_sdata` low, `done` low and `req_ready` high.
- R2: A frame holds 12 bits and is sent most significant first, with the converter sampling on each falling edge of `bus_sclk`. The bit order is: channel bit 2, channel bit 1, channel bit 0, then the range bit, then code bit 7 down to code bit 0.
- R3: Each shift clock period has a high phase and a low phase. The high phase lasts HI_CYC system cycles, the larger of ceil(SCLK_MIN_PERIOD_NS/2), ceil(DATA_SETUP_NS) and ceil(LOAD_LEAD_NS). The low phase lasts LO_CYC system cycles, the larger of ceil(SCLK_MIN_PERIOD_NS/2), ceil(DATA_HOLD_NS) and ceil(LOAD_SETUP_NS). All of these are measured in SYS_PERIOD_NS units; the defaults give 50 and 50.
- R4: `bus_sdata` changes only in the cycle in which `bus_sclk` goes high. It is therefore stable for the whole high phase before each falling edge and for the whole low phase after it.
- R5: `bus_load_n` stays high while bits are shifted. It falls only after the last low phase, stays low for LOAD_CYC = ceil(LOAD_PULSE_NS/SYS_PERIOD_NS) cycles (default 25), and `bus_sclk` is low whenever `bus_load_n` is low.
- R6: For an immediate write (`req_defer`=0), `bus_ldac_n` is low from the first frame cycle through the end of the latch pulse. For a deferred write it stays high for the whole write.
- R7: An accepted commit drives `bus_ldac_n` low for LDAC_CYC = ceil(LDAC_PULSE_NS/SYS_PERIOD_NS) cycles (default 25), with `bus_load_n` high. The update strobe never falls while the latch strobe is low or in the cycle after it has been low.
- R8: `req_ready` is low from the cycle after acceptance until the write or commit ends. A request presented while busy has no effect on the frame being sent.
- R9: `done` is high for exactly one cycle, in the cycle in which the latch strobe (for a write) or the update strobe (for a commit) returns high. `req_ready` is high again in that same cycle.
- R10: When a write request and a commit request are both valid while idle, the write wins. In that case `commit_ready` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a write |
| req_chan | input | 3 | Target channel number |
| req_range | input | 1 | Range-doubling bit placed in the frame |
| req_code | input | 8 | Output code placed in the frame |
| req_defer | input | 1 | 1: hold update strobe high (deferred), 0: hold it low (immediate) |
| commit_valid | input | 1 | Request for a global update pulse |
| commit_ready | output | 1 | Idle and no write request competing |
| done | output | 1 | One-cycle end-of-operation pulse |
| bus_sclk | output | 1 | Serial shift clock, idles low |
| bus_sdata | output | 1 | Serial data line |
| bus_load_n | output | 1 | Active-low latch strobe |
| bus_ldac_n | output | 1 | Active-low global update strobe |

## Verification
The reference model predicts every output on every cycle. It is tried with several frames:
- The all-zero frame on channel 0 and the all-ones frame on channel 7 with range set. These separate bit order and bit position errors from stuck lines.
- The alternating codes A5 and 5A, which expose swapped or shifted bits.

Immediate and deferred writes are both sent, and a commit follows the deferred write. Comparing them separates the held update strobe from the pulsed one and confirms that the update pulse stays clear of the latch pulse. A conflicting request is held during a busy frame, and a write and a commit are raised together, to show that busy requests are ignored and that writes take priority.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_LOAD,
    ST_LDAC
  } seq_state_t;

  // whole system cycles needed to cover an interval, rounded up
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // counter width able to hold value v
  function automatic int count_width(input int v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: once a count has run out it stays out until reloaded
  p_timer_rests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/dacseq_shifter.sv
module dacseq_shifter #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] frame,
  input  logic         advance,
  output logic         sdata,
  output logic         last
);
  localparam int RW = $clog2(N);

  logic [N-1:0]  sreg;
  logic [RW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      remain <= '0;
    end else if (load) begin
      sreg   <= frame;
      remain <= RW'(N - 1);
    end else if (advance) begin
      sreg   <= {sreg[N-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign sdata = sreg[N-1];
  assign last  = (remain == '0);

  // R2: the final bit is not shifted away until a new frame is loaded
  p_last_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> last);

endmodule

// File: rtl/dacbus_sequencer.sv
module dacbus_sequencer
  import dacseq_pkg::*;
#(
  parameter int SYS_PERIOD_NS      = 10,
  parameter int SCLK_MIN_PERIOD_NS = 1000,
  parameter int DATA_SETUP_NS      = 50,
  parameter int DATA_HOLD_NS       = 50,
  parameter int LOAD_LEAD_NS       = 50,
  parameter int LOAD_SETUP_NS      = 50,
  parameter int LOAD_PULSE_NS      = 250,
  parameter int LDAC_PULSE_NS      = 250,
  parameter int CHAN_W             = 3,
  parameter int CODE_W             = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_range,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_defer,
  input  logic              commit_valid,
  output logic              commit_ready,
  output logic              done,
  output logic              bus_sclk,
  output logic              bus_sdata,
  output logic              bus_load_n,
  output logic              bus_ldac_n
);
  localparam int FRAME_W  = CHAN_W + 1 + CODE_W;
  localparam int HALF_CYC = ns_to_cycles((SCLK_MIN_PERIOD_NS + 1) / 2, SYS_PERIOD_NS);
  localparam int HI_CYC   = max3(HALF_CYC, ns_to_cycles(DATA_SETUP_NS, SYS_PERIOD_NS),
                                 ns_to_cycles(LOAD_LEAD_NS, SYS_PERIOD_NS));
  localparam int LO_CYC   = max3(HALF_CYC, ns_to_cycles(DATA_HOLD_NS, SYS_PERIOD_NS),
                                 ns_to_cycles(LOAD_SETUP_NS, SYS_PERIOD_NS));
  localparam int LOAD_CYC = max3(1, ns_to_cycles(LOAD_PULSE_NS, SYS_PERIOD_NS), 1);
  localparam int LDAC_CYC = max3(1, ns_to_cycles(LDAC_PULSE_NS, SYS_PERIOD_NS), 1);
  localparam int TMR_W    = count_width(max3(HI_CYC, LO_CYC, max3(LOAD_CYC, LDAC_CYC, 1)));

  seq_state_t         state;
  logic               req_fire, commit_fire;
  logic               tmr_load, tmr_exp;
  logic [TMR_W-1:0]   tmr_val;
  logic               shift_adv, shift_last;
  logic [FRAME_W-1:0] frame_word;

  assign req_ready    = (state == ST_IDLE);
  assign commit_ready = req_ready && !req_valid;
  assign req_fire     = req_valid && req_ready;
  assign commit_fire  = commit_valid && commit_ready;
  assign frame_word   = {req_chan, req_range, req_code};
  assign shift_adv    = (state == ST_LO) && tmr_exp && !shift_last;

  // timer reload on every phase entry
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_fire) begin
          tmr_load = 1'b1;  tmr_val = TMR_W'(HI_CYC - 1);
        end else if (commit_fire) begin
          tmr_load = 1'b1;  tmr_val = TMR_W'(LDAC_CYC - 1);
        end
      end
      ST_HI: if (tmr_exp) begin
        tmr_load = 1'b1;  tmr_val = TMR_W'(LO_CYC - 1);
      end
      ST_LO: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = shift_last ? TMR_W'(LOAD_CYC - 1) : TMR_W'(HI_CYC - 1);
      end
      default: ;
    endcase
  end

  dacseq_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  dacseq_shifter #(.N(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .frame(frame_word),
    .advance(shift_adv), .sdata(bus_sdata), .last(shift_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bus_sclk   <= 1'b0;
      bus_load_n <= 1'b1;
      bus_ldac_n <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_fire) begin
            state      <= ST_HI;
            bus_sclk   <= 1'b1;
            bus_ldac_n <= req_defer;
          end else if (commit_fire) begin
            state      <= ST_LDAC;
            bus_ldac_n <= 1'b0;
          end
        end
        ST_HI: if (tmr_exp) begin
          state    <= ST_LO;
          bus_sclk <= 1'b0;
        end
        ST_LO: if (tmr_exp) begin
          if (shift_last) begin
            state      <= ST_LOAD;
            bus_load_n <= 1'b0;
          end else begin
            state    <= ST_HI;
            bus_sclk <= 1'b1;
          end
        end
        ST_LOAD: if (tmr_exp) begin
          state      <= ST_IDLE;
          bus_load_n <= 1'b1;
          bus_ldac_n <= 1'b1;
          done       <= 1'b1;
        end
        ST_LDAC: if (tmr_exp) begin
          state      <= ST_IDLE;
          bus_ldac_n <= 1'b1;
          done       <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_data_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_sdata) |-> bus_sclk);

  p_load_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_load_n |-> !bus_sclk);

  p_ldac_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ldac_n) |-> (bus_load_n && $past(bus_load_n)));

  p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_load_n && !bus_sclk));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && bus_load_n && bus_ldac_n));

endmodule

// File: tb/tb_dacbus_sequencer.sv
module tb_dacbus_sequencer;

  // timing restated from the requirements (10 ns system clock)
  localparam int HI    = 500 / 10;
  localparam int LO    = 500 / 10;
  localparam int LOADC = (250 + 9) / 10;
  localparam int LDACC = (250 + 9) / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_range = 1'b0, req_defer = 1'b0, commit_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic [7:0] req_code = '0;
  logic req_ready, commit_ready, done, bus_sclk, bus_sdata, bus_load_n, bus_ldac_n;

  always #5 clk = ~clk;

  dacbus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_range(req_range), .req_code(req_code),
    .req_defer(req_defer), .commit_valid(commit_valid), .commit_ready(commit_ready),
    .done(done), .bus_sclk(bus_sclk), .bus_sdata(bus_sdata),
    .bus_load_n(bus_load_n), .bus_ldac_n(bus_ldac_n)
  );

  typedef struct {
    logic sclk, sdata, load_n, ldac_n, done, ready;
  } exp_t;

  exp_t q[$];
  exp_t ex;
  int   tests = 0, fails = 0, cycles = 0;
  logic last_sdata = 1'b0;
  logic [11:0] want_frame = '0, cap_frame = '0;
  logic frame_op = 1'b0, prev_sclk = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      ex = '{0, 0, 1, 1, 0, 1};
      last_sdata = 1'b0;
    end else begin
      if (q.size() == 0 && req_valid) begin
        logic [11:0] f;
        f = {req_chan, req_range, req_code};
        want_frame = f;  cap_frame = '0;  frame_op = 1'b1;
        for (int b = 11; b >= 0; b--) begin
          for (int k = 0; k < HI; k++) q.push_back('{1, f[b], 1, req_defer, 0, 0});
          for (int k = 0; k < LO; k++) q.push_back('{0, f[b], 1, req_defer, 0, 0});
        end
        for (int k = 0; k < LOADC; k++) q.push_back('{0, f[0], 0, req_defer, 0, 0});
        q.push_back('{0, f[0], 1, 1, 1, 1});
      end else if (q.size() == 0 && commit_valid) begin
        frame_op = 1'b0;
        for (int k = 0; k < LDACC; k++) q.push_back('{0, last_sdata, 1, 0, 0, 0});
        q.push_back('{0, last_sdata, 1, 1, 1, 1});
      end
      if (q.size() > 0) ex = q.pop_front();
      else ex = '{0, last_sdata, 1, 1, 0, 1};
      last_sdata = ex.sdata;
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #3;
    if (rst_n) begin
      logic ok;
      ok = (bus_sclk === ex.sclk) && (bus_sdata === ex.sdata) &&
           (bus_load_n === ex.load_n) && (bus_ldac_n === ex.ldac_n) &&
           (done === ex.done) && (req_ready === ex.ready);
      tests++;
      if (!ok) begin
        fails++;
        if (bus_sclk !== ex.sclk)     $display("FAIL R3 sclk actual=%b expected=%b", bus_sclk, ex.sclk);
        if (bus_sdata !== ex.sdata)   $display("FAIL R4 sdata actual=%b expected=%b", bus_sdata, ex.sdata);
        if (bus_load_n !== ex.load_n) $display("FAIL R5 load_n actual=%b expected=%b", bus_load_n, ex.load_n);
        if (bus_ldac_n !== ex.ldac_n) $display("FAIL R6/R7 ldac_n actual=%b expected=%b", bus_ldac_n, ex.ldac_n);
        if (done !== ex.done)         $display("FAIL R9 done actual=%b expected=%b", done, ex.done);
        if (req_ready !== ex.ready)   $display("FAIL R8 ready actual=%b expected=%b", req_ready, ex.ready);
      end
      // R2: reassemble the frame as the converter would see it
      if (prev_sclk && !bus_sclk) cap_frame = {cap_frame[10:0], bus_sdata};
      prev_sclk = bus_sclk;
      if (done && frame_op) chk(cap_frame == want_frame, "R2 frame", cap_frame, want_frame);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic send(input logic [2:0] ch, input logic rg, input logic [7:0] cd, input logic df);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = ch; req_range = rg; req_code = cd; req_defer = df; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    while (!commit_ready) @(negedge clk);
    commit_valid = 1'b1;
    @(negedge clk);
    commit_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    chk(bus_sclk == 0 && bus_load_n == 1 && bus_ldac_n == 1 && bus_sdata == 0 && done == 0
        && req_ready == 1, "R1 reset levels",
        {bus_sclk, bus_load_n, bus_ldac_n, bus_sdata, done, req_ready}, 6'b011001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 R6: immediate, all-zero frame
    send(3'd0, 1'b0, 8'h00, 1'b0);
    wait_done();
    // R6 R7: deferred all-ones frame then commit
    send(3'd7, 1'b1, 8'hFF, 1'b1);
    wait_done();
    commit();
    wait_done();
    // R8: conflicting request held while busy
    send(3'd5, 1'b0, 8'hA5, 1'b1);
    req_chan = 3'd2; req_code = 8'h3C; req_range = 1'b1; req_valid = 1'b1;
    repeat (200) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    // R10: write and commit together
    @(negedge clk);
    req_chan = 3'd1; req_range = 1'b0; req_code = 8'h81; req_defer = 1'b1;
    req_valid = 1'b1; commit_valid = 1'b1;
    #1;
    chk(commit_ready == 0 && req_ready == 1, "R10 write priority",
        {commit_ready, req_ready}, 2'b01);
    @(negedge clk);
    req_valid = 1'b0; commit_valid = 1'b0;
    wait_done();
    commit();
    wait_done();
    // immediate alternating pattern
    send(3'd3, 1'b1, 8'h5A, 1'b0);
    wait_done();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule